// File: doc/BRIEF.md
# Hitless Reference Switch Sequencer with Phase Build-Out

This block is the digital controller that sits beside a clock multiplier's analog loop and protects the output clock when the input reference changes. Once per phase-detector cycle it receives a signed phase-error sample between the reference and the feedback clock. It drives three controls back into the loop: an enable for the phase detector, a select that switches the loop filter into its narrow-bandwidth setting, and an offset in oscillator cycles. That offset chooses which oscillator edge the feedback divider presents to the detector.

After reset the sequencer waits for the loop to lock before it arms. While armed, a large phase transient is taken as loss of lock, and a fixed recovery starts. The loop goes narrow and the detector is switched off. The feedback edge then moves to the oscillator edge nearest the new reference phase. The detector comes back on, and lock is confirmed again. After a hold timer runs out, wide bandwidth returns and the sequencer arms again. An external pin can force narrow bandwidth at any time. A static option input can skip the build-out step.

Top module: `hs_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the unarmed idle state after that edge: `pd_en`=1, `nbw_sel`=0 (with `nbw_pin` low), `fb_ofs`=0.
- R2: The block arms only after LOCK_N (8) consecutive valid samples inside the lock window. While it is unarmed, a sample of any size leaves `pd_en`=1 and `nbw_sel`=0.
- R3: While armed, a valid sample whose magnitude is at least 16 steps triggers the sequence. `pd_err` is two's complement and 1 LSB is 250 ps, so 16 steps is 4 ns; both signs count. A magnitude of 15 does not trigger. In the cycle after the trigger, `pd_en`=0 and `nbw_sel`=1.
- R4: With `pbo_en`=1, the detector stays off for a second cycle with `fb_ofs` unchanged. At the end of that cycle `fb_ofs` becomes (old + q) mod DIV (DIV=6). Here q is the trigger sample divided by the oscillator period (4 steps), rounded to the nearest integer, with halves rounded away from zero.
- R5: The detector is re-enabled right after the build-out cycle. With `pbo_en`=0 it is re-enabled one cycle after the disable cycle, and `fb_ofs` does not change.
- R6: Lock is confirmed after 8 consecutive valid samples with magnitude of at most 8 steps (2 ns). A sample of 9 steps or more restarts the count.
- R7: From the edge that confirms lock, `nbw_sel` stays 1 for exactly WBW_CYC (35 = 175 ns / 5 ns) more cycles. It then drops to 0 and the block is armed again.
- R8: A loss-of-lock sized sample during the recovery sequence does not restart it: `pd_en` stays 1 and `fb_ofs` is unchanged.
- R9: `nbw_pin`=1 forces `nbw_sel`=1 in every state, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_valid | input | 1 | A new phase-error sample is present this cycle |
| pd_err | input | ERR_W | Signed phase error in 250 ps steps |
| pbo_en | input | 1 | Static option: 1 enables phase build-out |
| nbw_pin | input | 1 | External request for narrow loop bandwidth |
| pd_en | output | 1 | Phase detector enable |
| nbw_sel | output | 1 | Narrow loop bandwidth select |
| fb_ofs | output | OFS_W | Feedback edge offset in oscillator cycles, 0..DIV-1 |

## Verification
The assertions hold on every cycle that a disabled detector always comes with narrow bandwidth, and that the detector only drops right after a valid sample of loss-of-lock size. They also check that the detector is never off for more than two cycles and that the offset moves only while the detector is off. The pin override and the offset range are checked on every cycle as well. Only the bench scenarios can show the arithmetic of the nearest-edge offset over the whole signed error range and the exact length of the hold window. The same goes for how the lock count restarts at the window boundary, and for the fact that events are ignored while unarmed or in mid-sequence.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

   typedef enum logic [2:0] {
      ST_UNARMED,
      ST_ARMED,
      ST_NARROW,
      ST_BUILD,
      ST_RELOCK,
      ST_HOLD
   } hs_state_e;

   function automatic int err_mag(input int e);
      return (e < 0) ? -e : e;
   endfunction

endpackage

// File: rtl/hs_lock_win.sv
module hs_lock_win
   import hs_seq_pkg::*;
#(
   parameter int ERR_W     = 8,
   parameter int WIN_STEPS = 8,
   parameter int LOCK_N    = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    vld,
   input  logic signed [ERR_W-1:0] err,
   output logic                    hit
);
   localparam int CW = $clog2(LOCK_N + 1);
   localparam logic [CW-1:0] LAST = CW'(LOCK_N - 1);

   logic [CW-1:0] cnt;
   logic          in_win;

   assign in_win = err_mag(int'(err)) <= WIN_STEPS;
   assign hit    = !clr && vld && in_win && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (vld) begin
         if (!in_win || cnt == LAST) cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hs_wbw_tmr.sv
module hs_wbw_tmr #(
   parameter int CYC = 35
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic expire
);
   localparam int CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt;

   assign expire = (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= CW'(CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/hs_pbo_calc.sv
module hs_pbo_calc
   import hs_seq_pkg::*;
#(
   parameter int ERR_W     = 8,
   parameter int VCO_STEPS = 4,
   parameter int DIV       = 6,
   parameter int OFS_W     = 3
) (
   input  logic signed [ERR_W-1:0] err,
   input  logic [OFS_W-1:0]        cur,
   output logic [OFS_W-1:0]        nxt
);
   int mag;
   int quo;
   int sum;
   int rem;

   always_comb begin
      mag = err_mag(int'(err));
      quo = (mag + VCO_STEPS / 2) / VCO_STEPS;
      if (err < 0) quo = -quo;
      sum = int'(cur) + quo;
      rem = sum % DIV;
      if (rem < 0) rem = rem + DIV;
      nxt = OFS_W'(rem);
   end
endmodule

// File: rtl/hs_seq.sv
module hs_seq
   import hs_seq_pkg::*;
#(
   parameter int ERR_W       = 8,
   parameter int STEP_PS     = 250,
   parameter int LOL_PS      = 4000,
   parameter int LOCK_PS     = 2000,
   parameter int LOCK_N      = 8,
   parameter int VCO_PS      = 1000,
   parameter int DIV         = 6,
   parameter int CLK_PS      = 5000,
   parameter int WBW_PS      = 175000,
   parameter bit PBO_PRESENT = 1'b1,
   localparam int OFS_W      = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    pd_valid,
   input  logic signed [ERR_W-1:0] pd_err,
   input  logic                    pbo_en,
   input  logic                    nbw_pin,
   output logic                    pd_en,
   output logic                    nbw_sel,
   output logic [OFS_W-1:0]        fb_ofs
);
   localparam int LOL_STEPS = LOL_PS / STEP_PS;
   localparam int WIN_STEPS = LOCK_PS / STEP_PS;
   localparam int VCO_STEPS = VCO_PS / STEP_PS;
   localparam int WBW_CYC   = WBW_PS / CLK_PS;

   if (WIN_STEPS >= LOL_STEPS) begin : g_bad_window
      $error("lock window must be tighter than the loss-of-lock threshold");
   end
   if (VCO_STEPS < 1) begin : g_bad_vco
      $error("oscillator period must span at least one error step");
   end
   if (WBW_CYC < 1 || LOCK_N < 1 || DIV < 2) begin : g_bad_count
      $error("timer, lock count and divider ratio must be positive");
   end
   if (LOL_STEPS >= (1 << (ERR_W - 1))) begin : g_bad_width
      $error("error width cannot represent the loss-of-lock threshold");
   end

   hs_state_e               state_q, state_d;
   logic signed [ERR_W-1:0] err_cap;
   logic [OFS_W-1:0]        ofs_q;
   logic [OFS_W-1:0]        ofs_nxt;
   logic                    trig;
   logic                    lock_clr;
   logic                    lock_hit;
   logic                    tmr_load;
   logic                    tmr_exp;
   logic                    seq_narrow;

   assign trig     = pd_valid && (err_mag(int'(pd_err)) >= LOL_STEPS);
   assign lock_clr = !(state_q == ST_UNARMED || state_q == ST_RELOCK);
   assign tmr_load = (state_q == ST_RELOCK) && lock_hit;

   hs_lock_win #(
      .ERR_W     (ERR_W),
      .WIN_STEPS (WIN_STEPS),
      .LOCK_N    (LOCK_N)
   ) u_lock (
      .clk (clk),
      .rst (rst),
      .clr (lock_clr),
      .vld (pd_valid),
      .err (pd_err),
      .hit (lock_hit)
   );

   hs_wbw_tmr #(
      .CYC (WBW_CYC)
   ) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .load   (tmr_load),
      .expire (tmr_exp)
   );

   if (PBO_PRESENT) begin : g_pbo
      hs_pbo_calc #(
         .ERR_W     (ERR_W),
         .VCO_STEPS (VCO_STEPS),
         .DIV       (DIV),
         .OFS_W     (OFS_W)
      ) u_pbo (
         .err (err_cap),
         .cur (ofs_q),
         .nxt (ofs_nxt)
      );
   end else begin : g_no_pbo
      assign ofs_nxt = ofs_q;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_UNARMED: if (lock_hit) state_d = ST_ARMED;
         ST_ARMED:   if (trig)     state_d = ST_NARROW;
         ST_NARROW:  state_d = (PBO_PRESENT && pbo_en) ? ST_BUILD : ST_RELOCK;
         ST_BUILD:   state_d = ST_RELOCK;
         ST_RELOCK:  if (lock_hit) state_d = ST_HOLD;
         ST_HOLD:    if (tmr_exp)  state_d = ST_ARMED;
         default:    state_d = ST_UNARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_UNARMED;
         err_cap <= '0;
         ofs_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_ARMED && trig) err_cap <= pd_err;
         if (state_q == ST_BUILD)         ofs_q   <= ofs_nxt;
      end
   end

   assign seq_narrow = (state_q == ST_NARROW) || (state_q == ST_BUILD) ||
                       (state_q == ST_RELOCK) || (state_q == ST_HOLD);
   assign pd_en   = !((state_q == ST_NARROW) || (state_q == ST_BUILD));
   assign nbw_sel = nbw_pin || seq_narrow;
   assign fb_ofs  = ofs_q;
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk
   import hs_seq_pkg::*;
#(
   parameter int ERR_W     = 8,
   parameter int LOL_STEPS = 16,
   parameter int DIV       = 6,
   parameter int OFS_W     = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    pd_valid,
   input logic signed [ERR_W-1:0] pd_err,
   input logic                    nbw_pin,
   input logic                    pd_en,
   input logic                    nbw_sel,
   input logic [OFS_W-1:0]        fb_ofs
);
   logic past_ok;
   logic big_evt;

   assign big_evt = pd_valid && (err_mag(int'(pd_err)) >= LOL_STEPS);

   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   AST_DET_OFF_NARROW: assert property (@(posedge clk) disable iff (rst)
      !pd_en |-> nbw_sel);                                              // R3
   AST_DET_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $fell(pd_en)) |-> $past(big_evt));                    // R3
   AST_DET_OFF_SHORT: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !pd_en && !$past(pd_en)) |=> pd_en);                  // R5
   AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(pd_en)) |-> $stable(fb_ofs));                   // R4
   AST_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
      int'(fb_ofs) < DIV);                                              // R4
   AST_PIN_NARROW: assert property (@(posedge clk) disable iff (rst)
      nbw_pin |-> nbw_sel);                                             // R9
endmodule

bind hs_seq hs_seq_chk #(
   .ERR_W     (ERR_W),
   .LOL_STEPS (LOL_STEPS),
   .DIV       (DIV),
   .OFS_W     (OFS_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pd_valid (pd_valid),
   .pd_err   (pd_err),
   .nbw_pin  (nbw_pin),
   .pd_en    (pd_en),
   .nbw_sel  (nbw_sel),
   .fb_ofs   (fb_ofs)
);

// File: tb/hs_seq_tb.sv
module hs_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LOL    = 16;
   localparam int WIN    = 8;
   localparam int VCO    = 4;
   localparam int DIVR   = 6;
   localparam int WBW_N  = 175000 / 5000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              pd_valid = 1'b0;
   logic signed [7:0] pd_err = '0;
   logic              pbo_en = 1'b1;
   logic              nbw_pin = 1'b0;
   logic              pd_en;
   logic              nbw_sel;
   logic [2:0]        fb_ofs;

   int checks = 0;
   int errs   = 0;
   int ofs_m  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hs_seq u_dut (
      .clk      (clk),
      .rst      (rst),
      .pd_valid (pd_valid),
      .pd_err   (pd_err),
      .pbo_en   (pbo_en),
      .nbw_pin  (nbw_pin),
      .pd_en    (pd_en),
      .nbw_sel  (nbw_sel),
      .fb_ofs   (fb_ofs)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int e);
      @(negedge clk);
      pd_err   = 8'(e);
      pd_valid = 1'b1;
   endtask

   function automatic int near_edge(input int e);
      int m;
      m = (e < 0) ? -e : e;
      m = (m + VCO / 2) / VCO;
      return (e < 0) ? -m : m;
   endfunction

   // expects one in-window sample already pending in RELOCK
   task automatic relock_hold();
      for (int i = 0; i < 6; i++) tick((i % 2 == 0) ? WIN : -WIN);
      tick(0);
      chk("R6 not yet locked nbw", int'(nbw_sel), 1);
      chk("R8 pd_en stays on", int'(pd_en), 1);
      chk("R8 offset unchanged", int'(fb_ofs), ofs_m);
      for (int i = 0; i < WBW_N; i++) begin
         tick(0);
         chk("R7 narrow during hold", int'(nbw_sel), 1);
      end
      tick(0);
      chk("R7 wide after hold", int'(nbw_sel), 0);
      chk("R7 detector on", int'(pd_en), 1);
   endtask

   task automatic run_seq(input int e, input bit with_bo);
      tick(e);
      tick(0);
      chk("R3 detector off", int'(pd_en), 0);
      chk("R3 narrow on", int'(nbw_sel), 1);
      if (with_bo) begin
         tick(0);
         chk("R4 offset before update", int'(fb_ofs), ofs_m);
         chk("R5 detector off in build", int'(pd_en), 0);
         ofs_m = ((ofs_m + near_edge(e)) % DIVR + DIVR) % DIVR;
      end
      tick(0);
      chk("R4 offset after build-out", int'(fb_ofs), ofs_m);
      chk("R5 detector re-enabled", int'(pd_en), 1);
      for (int i = 0; i < 6; i++) tick(WIN);
      tick(WIN + 1);
      tick(LOL + 4);
      tick(-WIN);
      relock_hold();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pd_en", int'(pd_en), 1);
      chk("R1 reset nbw", int'(nbw_sel), 0);
      chk("R1 reset offset", int'(fb_ofs), 0);
      rst = 1'b0;

      // unarmed: large transient ignored
      tick(40);
      tick(0);
      chk("R2 unarmed ignores lol nbw", int'(nbw_sel), 0);
      chk("R2 unarmed ignores lol pd_en", int'(pd_en), 1);
      for (int i = 0; i < 6; i++) tick(WIN);
      tick(WIN + 1);
      for (int i = 0; i < 7; i++) tick(-WIN);
      tick(-40);
      tick(0);
      chk("R2 seven samples do not arm", int'(nbw_sel), 0);
      chk("R2 seven samples pd_en", int'(pd_en), 1);
      for (int i = 0; i < 7; i++) tick(WIN);
      tick(LOL - 1);
      tick(-(LOL - 1));
      tick(0);
      chk("R3 below threshold no trigger", int'(nbw_sel), 0);
      chk("R3 below threshold pd_en", int'(pd_en), 1);

      // sweep all trigger magnitudes, both signs
      for (int e = -128; e <= 127; e++) begin
         if (e >= LOL || e <= -LOL) run_seq(e, 1'b1);
      end

      // build-out disabled
      pbo_en = 1'b0;
      run_seq(37, 1'b0);
      pbo_en = 1'b1;

      // external narrow pin while armed and idle
      @(negedge clk);
      nbw_pin = 1'b1;
      #1;
      chk("R9 pin forces narrow", int'(nbw_sel), 1);
      @(negedge clk);
      nbw_pin = 1'b0;
      #1;
      chk("R9 pin released", int'(nbw_sel), 0);

      // reset in mid-sequence
      tick(30);
      tick(0);
      chk("R3 trigger before reset", int'(pd_en), 0);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid reset pd_en", int'(pd_en), 1);
      chk("R1 mid reset nbw", int'(nbw_sel), 0);
      chk("R1 mid reset offset", int'(fb_ofs), 0);
      nbw_pin = 1'b1;
      #1;
      chk("R9 pin forces narrow while unarmed", int'(nbw_sel), 1);
      nbw_pin = 1'b0;
      rst = 1'b0;
      tick(-50);
      tick(0);
      chk("R2 unarmed after reset", int'(nbw_sel), 0);
      chk("R2 unarmed after reset pd_en", int'(pd_en), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog R7 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end
endmodule